// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home side of a directory cache-coherence scheme for a small number of memory blocks shared by `N_NODES` caching nodes. For each block it keeps a stable state, a full presence vector with one bit per node, a transient pending marker, the requester of the open transaction, an acknowledgement counter and the data word held in home memory. Requests arrive on a valid/ready message port. Replies, invalidations, forwarded interventions and retry notices leave on a second valid/ready port. Every message carries a source node, a destination node, a type and a block index.

The home node's own identifier is `N_NODES`, and caching nodes are numbered 0 to `N_NODES-1`. A read-shared request is answered from home memory, unless a node owns the block exclusively. In that case the request is forwarded to the owner, which sends the data straight to the requester and then reports completion to the home. A read-exclusive request to a shared block sends one invalidation to each other sharer, in ascending node order. The block then waits in a pending state until every acknowledgement has come back, and only then is exclusive data granted. A request that reaches a block with an open transaction is refused with a retry notice and is not queued.

The sequencer has three states. `FS_IDLE` accepts one inbound message. `FS_REPLY` holds a single outbound message until it is taken. `FS_INV` sends invalidations one per handshake. The transitions are: `FS_IDLE`→`FS_REPLY` on a request that produces one reply; `FS_IDLE`→`FS_INV` on a read-exclusive that has other sharers; `FS_REPLY`→`FS_IDLE` when `out_ready` is high; and `FS_INV`→`FS_IDLE` when the last invalidation is taken. Each block's stable state is one of `ST_UNC`, `ST_SHD` or `ST_EXC`. Its pending marker is one of `PD_NONE`, `PD_FWD_SH`, `PD_FWD_EX` or `PD_INV`.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every block is Uncached with an empty presence vector and zero memory data. `in_ready` is 1 and `out_valid` is 0. Inbound type codes are: read-shared 0, read-exclusive 1, writeback 2, invalidation acknowledgement 3, intervention completion 4. Outbound type codes are: shared data 0, exclusive data 1, invalidate 2, forward-for-read 3, forward-for-ownership 4, retry 5.
- R2: A read-shared request (0) to an Uncached or Shared block returns shared data (0) with the home memory word to the requester. The requester's presence bit is set and the block becomes Shared.
- R3: A read-shared request (0) to an Exclusive block sends forward-for-read (3) to the owner, with `out_req` set to the requester. When the completion (4) arrives, the block becomes Shared with both owner and requester present.
- R4: A read-exclusive request (1) to a Shared block with other sharers sends invalidate (2) to each other sharer in ascending node order. The acknowledgement count is set to the number of those sharers. Exclusive data (1) goes to the requester only when the last acknowledgement (3) arrives.
- R5: A read-exclusive request (1) to an Uncached block, or from the only sharer of a Shared block, is granted at once with exclusive data (1) and no invalidations.
- R6: A read-exclusive request (1) to an Exclusive block sends forward-for-ownership (4) to the owner, with `out_req` set to the requester. After the completion, the requester is the sole owner.
- R7: Any read-shared or read-exclusive request to a block with an open transaction is answered with retry (5) to the requester, and the directory is left unchanged.
- R8: A writeback (2) from the owner of an Exclusive block makes the block Uncached with an empty vector. Home memory takes `in_data` only when `in_dirty` is 1. A writeback from any other node, or to a block that is not Exclusive, has no effect.
- R9: An intervention completion (4) writes `in_data` into home memory when `in_dirty` is 1 and leaves memory as it was when `in_dirty` is 0.
- R10: An acknowledgement (3) or completion (4) to a block with no matching open transaction has no effect.
- R11: An inbound message whose `in_dst` is not the home identifier (`N_NODES`) is consumed and has no effect.
- R12: An outbound message holds all its fields until `out_ready` is seen. `in_ready` is low whenever an outbound message is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound message present |
| in_ready | output | 1 | Inbound message accepted this cycle |
| in_src | input | ID_W | Sending node |
| in_dst | input | ID_W | Addressed node; must equal the home identifier |
| in_type | input | 3 | Inbound message type |
| in_blk | input | BLK_W | Block index |
| in_data | input | DATA_W | Data carried by writeback or completion |
| in_dirty | input | 1 | Carried data is modified |
| out_valid | output | 1 | Outbound message present |
| out_ready | input | 1 | Outbound message taken |
| out_src | output | ID_W | Always the home identifier |
| out_dst | output | ID_W | Target node |
| out_type | output | 3 | Outbound message type |
| out_blk | output | BLK_W | Block index |
| out_data | output | DATA_W | Home memory word for data replies |
| out_req | output | ID_W | Original requester, for forwards and invalidations |

## Verification
The bench builds the block with its defaults: four caching nodes, four blocks and 8-bit data. With four nodes, a block can have three sharers at once, so a two-invalidation round with an interleaved retry and a partial acknowledgement count can be exercised. With four blocks, one block can sit pending while others are served, and each owner/sharer pattern can be set up on its own block without disturbing the rest. The 8-bit data makes clean and dirty memory updates easy to tell apart by value.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {ST_UNC, ST_SHD, ST_EXC} stable_e;
    typedef enum logic [1:0] {PD_NONE, PD_FWD_SH, PD_FWD_EX, PD_INV} pend_e;
    typedef enum logic [2:0] {
        RQ_RD_SH    = 3'd0,
        RQ_RD_EX    = 3'd1,
        RQ_WB       = 3'd2,
        RQ_INV_ACK  = 3'd3,
        RQ_FWD_DONE = 3'd4
    } req_e;
    typedef enum logic [2:0] {
        RS_DATA_SH = 3'd0,
        RS_DATA_EX = 3'd1,
        RS_INV     = 3'd2,
        RS_FWD_SH  = 3'd3,
        RS_FWD_EX  = 3'd4,
        RS_NACK    = 3'd5
    } rsp_e;
    typedef enum logic [1:0] {FS_IDLE, FS_REPLY, FS_INV} fsm_e;
endpackage

// File: rtl/coh_popcount.sv
module coh_popcount #(
    parameter int W  = 4,
    parameter int CW = 3
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/coh_low_pick.sv
module coh_low_pick #(
    parameter int W  = 4,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
    import coh_pkg::*;
#(
    parameter int N_NODES  = 4,
    parameter int N_BLOCKS = 4,
    parameter int DATA_W   = 8,
    localparam int ID_W    = $clog2(N_NODES + 1),
    localparam int BLK_W   = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ID_W-1:0]   in_src,
    input  logic [ID_W-1:0]   in_dst,
    input  logic [2:0]        in_type,
    input  logic [BLK_W-1:0]  in_blk,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_dirty,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ID_W-1:0]   out_src,
    output logic [ID_W-1:0]   out_dst,
    output logic [2:0]        out_type,
    output logic [BLK_W-1:0]  out_blk,
    output logic [DATA_W-1:0] out_data,
    output logic [ID_W-1:0]   out_req
);
    localparam int CNT_W = $clog2(N_NODES + 1);
    localparam logic [ID_W-1:0] HOME_ID = ID_W'(N_NODES);

    // directory storage
    stable_e             st_q   [N_BLOCKS];
    pend_e               pd_q   [N_BLOCKS];
    logic [N_NODES-1:0]  shr_q  [N_BLOCKS];
    logic [ID_W-1:0]     preq_q [N_BLOCKS];
    logic [CNT_W-1:0]    cnt_q  [N_BLOCKS];
    logic [DATA_W-1:0]   mem_q  [N_BLOCKS];

    // sequencer and held outbound message
    fsm_e                fs_q, fs_d;
    rsp_e                o_type_q;
    logic [ID_W-1:0]     o_dst_q, o_req_q;
    logic [BLK_W-1:0]    o_blk_q;
    logic [DATA_W-1:0]   o_data_q;
    logic [N_NODES-1:0]  inv_left_q;

    // current block view
    stable_e             cur_st;
    pend_e               cur_pd;
    logic [N_NODES-1:0]  cur_shr, src_bit, preq_bit, others;
    logic [ID_W-1:0]     cur_preq, own_idx, inv_idx;
    logic [CNT_W-1:0]    cur_cnt, oth_cnt;
    logic [DATA_W-1:0]   cur_mem;
    logic                own_any, inv_any;
    logic                accept, for_me;

    assign accept   = in_valid && (fs_q == FS_IDLE);
    assign for_me   = (in_dst == HOME_ID);
    assign cur_st   = st_q[in_blk];
    assign cur_pd   = pd_q[in_blk];
    assign cur_shr  = shr_q[in_blk];
    assign cur_preq = preq_q[in_blk];
    assign cur_cnt  = cnt_q[in_blk];
    assign cur_mem  = mem_q[in_blk];
    assign others   = cur_shr & ~src_bit;

    always_comb begin
        for (int i = 0; i < N_NODES; i++) begin
            src_bit[i]  = (in_src == ID_W'(i));
            preq_bit[i] = (cur_preq == ID_W'(i));
        end
    end

    coh_popcount #(.W(N_NODES), .CW(CNT_W)) u_oth_cnt (
        .vec (others),
        .cnt (oth_cnt)
    );

    coh_low_pick #(.W(N_NODES), .IW(ID_W)) u_owner (
        .vec (cur_shr),
        .idx (own_idx),
        .any (own_any)
    );

    coh_low_pick #(.W(N_NODES), .IW(ID_W)) u_inv_pick (
        .vec (inv_left_q),
        .idx (inv_idx),
        .any (inv_any)
    );

    // request decode
    logic                dec_reply, dec_inv, upd;
    rsp_e                dec_type;
    logic [ID_W-1:0]     dec_dst;
    logic [DATA_W-1:0]   dec_data;
    stable_e             n_st;
    pend_e               n_pd;
    logic [N_NODES-1:0]  n_shr;
    logic [ID_W-1:0]     n_preq;
    logic [CNT_W-1:0]    n_cnt;
    logic [DATA_W-1:0]   n_mem;

    always_comb begin
        dec_reply = 1'b0;
        dec_inv   = 1'b0;
        upd       = 1'b0;
        dec_type  = RS_NACK;
        dec_dst   = in_src;
        dec_data  = cur_mem;
        n_st      = cur_st;
        n_pd      = cur_pd;
        n_shr     = cur_shr;
        n_preq    = cur_preq;
        n_cnt     = cur_cnt;
        n_mem     = cur_mem;
        if (accept && for_me) begin
            unique case (in_type)
                RQ_RD_SH: begin
                    dec_reply = 1'b1;
                    if (cur_pd != PD_NONE) begin
                        dec_type = RS_NACK;
                    end else if (cur_st == ST_EXC) begin
                        dec_type = RS_FWD_SH;
                        dec_dst  = own_idx;
                        upd      = 1'b1;
                        n_pd     = PD_FWD_SH;
                        n_preq   = in_src;
                    end else begin
                        dec_type = RS_DATA_SH;
                        upd      = 1'b1;
                        n_shr    = cur_shr | src_bit;
                        n_st     = ST_SHD;
                    end
                end
                RQ_RD_EX: begin
                    if (cur_pd != PD_NONE) begin
                        dec_reply = 1'b1;
                        dec_type  = RS_NACK;
                    end else if (cur_st == ST_EXC) begin
                        dec_reply = 1'b1;
                        dec_type  = RS_FWD_EX;
                        dec_dst   = own_idx;
                        upd       = 1'b1;
                        n_pd      = PD_FWD_EX;
                        n_preq    = in_src;
                    end else if (others == '0) begin
                        dec_reply = 1'b1;
                        dec_type  = RS_DATA_EX;
                        upd       = 1'b1;
                        n_shr     = src_bit;
                        n_st      = ST_EXC;
                    end else begin
                        dec_inv = 1'b1;
                        upd     = 1'b1;
                        n_pd    = PD_INV;
                        n_preq  = in_src;
                        n_cnt   = oth_cnt;
                    end
                end
                RQ_WB: begin
                    if (cur_pd == PD_NONE && cur_st == ST_EXC && cur_shr == src_bit) begin
                        upd   = 1'b1;
                        n_st  = ST_UNC;
                        n_shr = '0;
                        if (in_dirty) n_mem = in_data;
                    end
                end
                RQ_INV_ACK: begin
                    if (cur_pd == PD_INV && cur_cnt != '0) begin
                        upd   = 1'b1;
                        n_cnt = cur_cnt - CNT_W'(1);
                        if (cur_cnt == CNT_W'(1)) begin
                            n_pd      = PD_NONE;
                            n_st      = ST_EXC;
                            n_shr     = preq_bit;
                            dec_reply = 1'b1;
                            dec_type  = RS_DATA_EX;
                            dec_dst   = cur_preq;
                        end
                    end
                end
                RQ_FWD_DONE: begin
                    if (cur_pd == PD_FWD_SH || cur_pd == PD_FWD_EX) begin
                        upd  = 1'b1;
                        n_pd = PD_NONE;
                        if (in_dirty) n_mem = in_data;
                        if (cur_pd == PD_FWD_SH) begin
                            n_shr = cur_shr | preq_bit;
                            n_st  = ST_SHD;
                        end else begin
                            n_shr = preq_bit;
                            n_st  = ST_EXC;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // sequencer next state
    always_comb begin
        fs_d = fs_q;
        unique case (fs_q)
            FS_IDLE: begin
                if (dec_inv)        fs_d = FS_INV;
                else if (dec_reply) fs_d = FS_REPLY;
            end
            FS_REPLY: begin
                if (out_ready) fs_d = FS_IDLE;
            end
            FS_INV: begin
                if (out_ready && ((inv_left_q & ~(N_NODES'(1) << inv_idx)) == '0))
                    fs_d = FS_IDLE;
            end
            default: fs_d = FS_IDLE;
        endcase
    end

    // sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= FS_IDLE;
        else        fs_q <= fs_d;
    end

    // held outbound message and invalidation walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_type_q   <= RS_NACK;
            o_dst_q    <= '0;
            o_req_q    <= '0;
            o_blk_q    <= '0;
            o_data_q   <= '0;
            inv_left_q <= '0;
        end else if (fs_q == FS_IDLE) begin
            if (dec_reply || dec_inv) begin
                o_type_q <= dec_type;
                o_dst_q  <= dec_dst;
                o_req_q  <= in_src;
                o_blk_q  <= in_blk;
                o_data_q <= dec_data;
            end
            if (dec_inv) inv_left_q <= others;
        end else if (fs_q == FS_INV && out_ready) begin
            inv_left_q <= inv_left_q & ~(N_NODES'(1) << inv_idx);
        end
    end

    // directory update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < N_BLOCKS; b++) begin
                st_q[b]   <= ST_UNC;
                pd_q[b]   <= PD_NONE;
                shr_q[b]  <= '0;
                preq_q[b] <= '0;
                cnt_q[b]  <= '0;
                mem_q[b]  <= '0;
            end
        end else if (upd) begin
            st_q[in_blk]   <= n_st;
            pd_q[in_blk]   <= n_pd;
            shr_q[in_blk]  <= n_shr;
            preq_q[in_blk] <= n_preq;
            cnt_q[in_blk]  <= n_cnt;
            mem_q[in_blk]  <= n_mem;
        end
    end

    // outputs
    always_comb begin
        in_ready  = (fs_q == FS_IDLE);
        out_valid = (fs_q != FS_IDLE);
        out_src   = HOME_ID;
        out_blk   = o_blk_q;
        out_data  = o_data_q;
        out_req   = o_req_q;
        if (fs_q == FS_INV) begin
            out_type = RS_INV;
            out_dst  = inv_idx;
        end else begin
            out_type = o_type_q;
            out_dst  = o_dst_q;
        end
    end

    // R12: a presented message holds until taken
    a_r12_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_type) && $stable(out_dst)
                                    && $stable(out_blk) && $stable(out_data));

    // R4/R5: exclusive data only ever leaves with the receiver as sole sharer
    a_r5_grant_sole: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_type == RS_DATA_EX |-> shr_q[out_blk] == (N_NODES'(1) << out_dst));

    // R12: no inbound accept while a reply is outstanding
    a_r12_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    for (genvar g = 0; g < N_BLOCKS; g++) begin : g_blk_chk
        // R1: an Exclusive block has exactly one presence bit
        a_r1_exc_single: assert property (@(posedge clk) disable iff (!rst_n)
            st_q[g] == ST_EXC && pd_q[g] == PD_NONE |-> $countones(shr_q[g]) == 1);
        // R1: an Uncached block has no presence bits
        a_r1_unc_empty: assert property (@(posedge clk) disable iff (!rst_n)
            st_q[g] == ST_UNC |-> shr_q[g] == '0);
        // R4: an invalidation round always has acknowledgements outstanding
        a_r4_cnt_live: assert property (@(posedge clk) disable iff (!rst_n)
            pd_q[g] == PD_INV |-> cnt_q[g] != '0);
        // R7: the stable state does not move while a transaction is open
        a_r7_pend_stable: assert property (@(posedge clk) disable iff (!rst_n)
            pd_q[g] != PD_NONE |=> (pd_q[g] == PD_NONE || $stable(st_q[g])));
    end
endmodule

// File: tb/coh_home_dir_tb.sv
module coh_home_dir_tb;
    localparam int N_NODES = 4;
    localparam int N_BLOCKS = 4;
    localparam int DATA_W = 8;
    localparam int ID_W = 3;
    localparam int BLK_W = 2;
    localparam logic [2:0] HOME = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready, in_dirty = 1'b0;
    logic [ID_W-1:0] in_src = '0, in_dst = HOME;
    logic [2:0] in_type = '0;
    logic [BLK_W-1:0] in_blk = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic out_valid, out_ready = 1'b0;
    logic [ID_W-1:0] out_src, out_dst, out_req;
    logic [2:0] out_type;
    logic [BLK_W-1:0] out_blk;
    logic [DATA_W-1:0] out_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    coh_home_dir #(.N_NODES(N_NODES), .N_BLOCKS(N_BLOCKS), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src), .in_dst(in_dst),
        .in_type(in_type), .in_blk(in_blk), .in_data(in_data), .in_dirty(in_dirty),
        .out_valid(out_valid), .out_ready(out_ready), .out_src(out_src), .out_dst(out_dst),
        .out_type(out_type), .out_blk(out_blk), .out_data(out_data), .out_req(out_req)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] src, input logic [2:0] dst, input logic [2:0] typ,
                        input logic [1:0] blk, input logic [7:0] data, input logic dirty);
        @(negedge clk);
        in_src = src; in_dst = dst; in_type = typ; in_blk = blk;
        in_data = data; in_dirty = dirty; in_valid = 1'b1;
        for (int w = 0; w < 50 && !in_ready; w++) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [2:0] etyp, input logic [2:0] edst,
                              input logic [1:0] eblk, input logic [7:0] edata,
                              input logic [2:0] ereq, input int hold);
        for (int w = 0; w < 20 && !out_valid; w++) @(negedge clk);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(in_ready == 1'b0, {req, " in_ready low while held"}, in_ready, 0);
        end
        chk(out_valid == 1'b1, {req, " out_valid"}, out_valid, 1);
        chk(out_type == etyp && out_dst == edst && out_blk == eblk && out_src == HOME,
            {req, " type/dst/blk/src"}, {out_type, out_dst, out_blk, out_src},
            {etyp, edst, eblk, HOME});
        if (etyp == 3'd0 || etyp == 3'd1)
            chk(out_data == edata, {req, " data"}, out_data, edata);
        if (etyp == 3'd3 || etyp == 3'd4 || etyp == 3'd2)
            chk(out_req == ereq, {req, " requester"}, out_req, ereq);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic expect_none(input string req);
        int seen = 0;
        for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            if (out_valid) seen = 1;
        end
        chk(seen == 0, {req, " no outbound message"}, seen, 0);
    endtask

    typedef struct packed {
        logic [2:0] src;
        logic [2:0] typ;
        logic [1:0] blk;
        logic [7:0] data;
        logic       dirty;
        logic       has;
        logic [2:0] etyp;
        logic [2:0] edst;
        logic [7:0] edata;
        logic [2:0] ereq;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 3'd0, 2'd0, 8'h00, 1'b0, 1'b1, 3'd0, 3'd1, 8'h00, 3'd0, 4'd2},  // R2 uncached read
        '{3'd2, 3'd0, 2'd0, 8'h00, 1'b0, 1'b1, 3'd0, 3'd2, 8'h00, 3'd0, 4'd2},  // R2 shared read
        '{3'd1, 3'd1, 2'd0, 8'h00, 1'b0, 1'b1, 3'd2, 3'd2, 8'h00, 3'd1, 4'd4},  // R4 invalidate node 2
        '{3'd3, 3'd0, 2'd0, 8'h00, 1'b0, 1'b1, 3'd5, 3'd3, 8'h00, 3'd0, 4'd7},  // R7 retry
        '{3'd2, 3'd3, 2'd0, 8'h00, 1'b0, 1'b1, 3'd1, 3'd1, 8'h00, 3'd0, 4'd4},  // R4 grant after ack
        '{3'd2, 3'd0, 2'd0, 8'h00, 1'b0, 1'b1, 3'd3, 3'd1, 8'h00, 3'd2, 4'd3},  // R3 forward to owner
        '{3'd1, 3'd4, 2'd0, 8'h5a, 1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 3'd0, 4'd9},  // R9 dirty completion
        '{3'd3, 3'd0, 2'd0, 8'h00, 1'b0, 1'b1, 3'd0, 3'd3, 8'h5a, 3'd0, 4'd9},  // R9 memory updated
        '{3'd0, 3'd1, 2'd1, 8'h00, 1'b0, 1'b1, 3'd1, 3'd0, 8'h00, 3'd0, 4'd5},  // R5 uncached to exclusive
        '{3'd0, 3'd2, 2'd1, 8'h33, 1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 3'd0, 4'd8},  // R8 dirty writeback
        '{3'd2, 3'd0, 2'd1, 8'h00, 1'b0, 1'b1, 3'd0, 3'd2, 8'h33, 3'd0, 4'd8},  // R8 memory holds 33
        '{3'd2, 3'd1, 2'd1, 8'h00, 1'b0, 1'b1, 3'd1, 3'd2, 8'h33, 3'd0, 4'd5},  // R5 sole sharer upgrade
        '{3'd2, 3'd2, 2'd1, 8'h77, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 3'd0, 4'd8},  // R8 clean writeback
        '{3'd3, 3'd0, 2'd1, 8'h00, 1'b0, 1'b1, 3'd0, 3'd3, 8'h33, 3'd0, 4'd8},  // R8 memory unchanged
        '{3'd1, 3'd2, 2'd1, 8'h99, 1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 3'd0, 4'd8},  // R8 non-owner writeback
        '{3'd1, 3'd0, 2'd1, 8'h00, 1'b0, 1'b1, 3'd0, 3'd1, 8'h33, 3'd0, 4'd8},  // R8 still 33
        '{3'd0, 3'd3, 2'd2, 8'h00, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 3'd0, 4'd10}, // R10 stray ack
        '{3'd0, 3'd0, 2'd2, 8'h00, 1'b0, 1'b1, 3'd0, 3'd0, 8'h00, 3'd0, 4'd10}  // R10 block not pending
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
        chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);

        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("vec%0d R%0d", v, VECS[v].tag);
            send(VECS[v].src, HOME, VECS[v].typ, VECS[v].blk, VECS[v].data, VECS[v].dirty);
            if (VECS[v].has)
                expect_out(tag, VECS[v].etyp, VECS[v].edst, VECS[v].blk,
                           VECS[v].edata, VECS[v].ereq, 0);
            else
                expect_none(tag);
        end

        // R4: block 0 shared by nodes 1,2,3; node 2 upgrades -> invalidate 1 then 3
        send(3'd2, HOME, 3'd1, 2'd0, 8'h00, 1'b0);
        expect_out("R4 first invalidate", 3'd2, 3'd1, 2'd0, 8'h00, 3'd2, 0);
        expect_out("R4 second invalidate", 3'd2, 3'd3, 2'd0, 8'h00, 3'd2, 0);
        send(3'd1, HOME, 3'd3, 2'd0, 8'h00, 1'b0);
        expect_none("R4 partial acks");
        send(3'd0, HOME, 3'd0, 2'd0, 8'h00, 1'b0);
        expect_out("R7 retry during invalidation", 3'd5, 3'd0, 2'd0, 8'h00, 3'd0, 0);
        send(3'd3, HOME, 3'd3, 2'd0, 8'h00, 1'b0);
        expect_out("R4 grant after last ack", 3'd1, 3'd2, 2'd0, 8'h5a, 3'd0, 0);

        // R6: ownership transfer 2 -> 0, then dirty data lands in memory (R9)
        send(3'd0, HOME, 3'd1, 2'd0, 8'h00, 1'b0);
        expect_out("R6 forward for ownership", 3'd4, 3'd2, 2'd0, 8'h00, 3'd0, 0);
        send(3'd2, HOME, 3'd4, 2'd0, 8'hc3, 1'b1);
        expect_none("R6 completion");
        send(3'd0, HOME, 3'd2, 2'd0, 8'h11, 1'b0);
        expect_none("R6 new owner writeback");
        send(3'd1, HOME, 3'd0, 2'd0, 8'h00, 1'b0);
        expect_out("R9 R6 memory from completion", 3'd0, 3'd1, 2'd0, 8'hc3, 3'd0, 0);

        // R9: clean completion leaves memory alone (block 3)
        send(3'd1, HOME, 3'd1, 2'd3, 8'h00, 1'b0);
        expect_out("R5 block 3 exclusive", 3'd1, 3'd1, 2'd3, 8'h00, 3'd0, 0);
        send(3'd2, HOME, 3'd0, 2'd3, 8'h00, 1'b0);
        expect_out("R3 forward block 3", 3'd3, 3'd1, 2'd3, 8'h00, 3'd2, 0);
        send(3'd1, HOME, 3'd4, 2'd3, 8'hee, 1'b0);
        expect_none("R9 clean completion");
        send(3'd3, HOME, 3'd0, 2'd3, 8'h00, 1'b0);
        expect_out("R9 memory unchanged", 3'd0, 3'd3, 2'd3, 8'h00, 3'd0, 0);

        // R11: message for another node is ignored (block 2 shared by node 0 only)
        send(3'd2, 3'd1, 3'd1, 2'd2, 8'h00, 1'b0);
        expect_none("R11 misaddressed");
        send(3'd0, HOME, 3'd1, 2'd2, 8'h00, 1'b0);
        expect_out("R11 R5 directory untouched", 3'd1, 3'd0, 2'd2, 8'h00, 3'd0, 0);

        // R12: back-pressure holds the forward
        send(3'd3, HOME, 3'd0, 2'd2, 8'h00, 1'b0);
        expect_out("R12 held forward", 3'd3, 3'd0, 2'd2, 8'h00, 3'd3, 4);
        send(3'd0, HOME, 3'd4, 2'd2, 8'h00, 1'b0);
        expect_none("R3 completion block 2");
        send(3'd1, HOME, 3'd1, 2'd2, 8'h00, 1'b0);
        expect_out("R3 both present, invalidate owner", 3'd2, 3'd0, 2'd2, 8'h00, 3'd1, 0);
        expect_out("R3 both present, invalidate reader", 3'd2, 3'd3, 2'd2, 8'h00, 3'd1, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule